// File: doc/BRIEF.md
# Configurable Clock Divider Bank

This block is the digital divider network that sits behind the oscillator of a clock driver. One fast source clock feeds a single free-running 4-bit counter. Four output groups (A, B, C, D) and one feedback clock are all decoded from that counter, so their rising edges line up.

Each group has its own select pin that picks one of two even ratios. The feedback clock has a select pin of its own, and its output goes to an external phase comparator.

A source mux normally clocks the counter from the oscillator clock. When the loop is bypassed, the mux takes one of two other clocks instead: a reference clock or a test clock. A single active-high input clears the counter and holds every output low.

Select changes are taken into a register only at the wrap of the counter, so a change of ratio never produces a short pulse.

Top module: `clkdiv_bank`

## Requirements
- R1: `outA` has a period of 2 source cycles when `selA` is 0 and 4 source cycles when `selA` is 1.
- R2: `outB`, `outC` and `outD` each have a period of 4 source cycles when their own select bit is 0 and 8 source cycles when it is 1.
- R3: `fbOut` has a period of 8 source cycles when `fbSelect` is 1 and 16 source cycles when `fbSelect` is 0.
- R4: Every output is high for exactly half of its period.
- R5: While `masterReset` is 1, every output is low, and this takes effect without waiting for a clock edge.
- R6: The first source edge after `masterReset` falls drives every output high on that same edge. After that, each rising edge of `fbOut` coincides with rising edges on all groups.
- R7: A change on `selA`..`selD` or `fbSelect` takes effect only at the next wrap of the 16-count frame. Until then, the old ratio continues.
- R8: With `pllEnable` at 0 and `refSelect` at 1, the divider is clocked from `testClk`, and periods scale with that clock.
- R9: With `pllEnable` at 0 and `refSelect` at 0, the divider is clocked from `oscClk`.
- R10: Both bits of `outC` are equal at all times, and all five bits of `outD` are equal at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vcoClk | input | 1 | Fast oscillator clock used in normal operation |
| testClk | input | 1 | External test clock used in bypass when `refSelect` is 1 |
| oscClk | input | 1 | Reference clock used in bypass when `refSelect` is 0 |
| pllEnable | input | 1 | 1 = clock from `vcoClk`, 0 = bypass |
| refSelect | input | 1 | Bypass source choice: 1 = `testClk`, 0 = `oscClk` |
| masterReset | input | 1 | 1 = clear counter and force all outputs low |
| selA | input | 1 | Group A ratio: 0 = ÷2, 1 = ÷4 |
| selB | input | 1 | Group B ratio: 0 = ÷4, 1 = ÷8 |
| selC | input | 1 | Group C ratio: 0 = ÷4, 1 = ÷8 |
| selD | input | 1 | Group D ratio: 0 = ÷4, 1 = ÷8 |
| fbSelect | input | 1 | Feedback ratio: 1 = ÷8, 0 = ÷16 |
| outA | output | 1 | Group A clock |
| outB | output | 1 | Group B clock |
| outC | output | 2 | Group C clocks, identical copies |
| outD | output | 5 | Group D clocks, identical copies |
| fbOut | output | 1 | Feedback clock for the phase comparator |

## Verification
The bench runs all 32 combinations of group selects and feedback select, and measures period and high time on every output.

A design that picked the wrong counter tap would show a doubled or halved period. A decode that is not phase-locked to the wrap would show a skewed high time.

A select is changed in the middle of a frame and the rising edges of `outA` are counted up to the next wrap. A design that applied the change at once would count 3 edges instead of 7.

Reset is asserted in the middle of a run and then released. The bench checks that the outputs drop without a clock edge, and that every output rises together on the first edge afterwards. A counter left in any other state would stagger those edges.

Both bypass paths are measured against their own clock periods, which catches a swapped mux leg.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CNT_W   = 4;
  localparam int NUM_GRP = 4;
  localparam int C_N     = 2;
  localparam int D_N     = 5;
  localparam int TAP_W   = $clog2(CNT_W);
  // counter bit used for the faster ratio of each path; the slower ratio is the next bit up
  localparam int A_BASE   = 0;
  localparam int BCD_BASE = 1;
  localparam int FB_FAST  = 2;
  localparam int FB_SLOW  = 3;

  typedef struct packed {
    logic               wrap;
    logic [CNT_W-1:0]   cntNext;
    logic [NUM_GRP-1:0] grpSel;
    logic               fbSel;
  } ctrl_t;
endpackage

// File: rtl/clkdiv_srcmux.sv
`timescale 1ns/1ps
module clkdiv_srcmux (
  input  logic vcoClk,
  input  logic testClk,
  input  logic oscClk,
  input  logic pllEnable,
  input  logic refSelect,
  output logic srcClk
);
  logic bypassClk;
  assign bypassClk = refSelect ? testClk : oscClk;
  assign srcClk    = pllEnable ? vcoClk : bypassClk;
endmodule

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rstHigh,
  input  logic [NUM_GRP-1:0] rawSel,
  input  logic               rawFb,
  output ctrl_t              ctl
);
  logic [CNT_W-1:0]   cnt;
  logic [NUM_GRP-1:0] selReg;
  logic               fbReg;
  logic               live;
  logic               wrap;

  assign wrap = &cnt;

  // counter rests at all ones so the first edge after reset is a wrap
  always_ff @(posedge clk or posedge rstHigh) begin
    if (rstHigh) begin
      cnt    <= '1;
      selReg <= '0;
      fbReg  <= 1'b0;
      live   <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      live <= 1'b1;
      if (wrap) begin
        selReg <= rawSel;
        fbReg  <= rawFb;
      end
    end
  end

  always_comb begin
    ctl.wrap    = wrap;
    ctl.cntNext = cnt + 1'b1;
    ctl.grpSel  = wrap ? rawSel : selReg;
    ctl.fbSel   = wrap ? rawFb  : fbReg;
  end

  // R7: the held selection moves only on a wrap edge
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rstHigh)
    (live && !wrap) |=> ($stable(selReg) && $stable(fbReg)));
endmodule

// File: rtl/clkdiv_datapath.sv
`timescale 1ns/1ps
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rstHigh,
  input  ctrl_t              ctl,
  output logic [NUM_GRP-1:0] grpOut,
  output logic               fbOut
);
  logic [TAP_W-1:0] fbTap;
  logic [1:0]       age;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int BASE = (g == 0) ? A_BASE : BCD_BASE;
    logic [TAP_W-1:0] tap;
    assign tap = TAP_W'(BASE) + TAP_W'(ctl.grpSel[g]);
    always_ff @(posedge clk or posedge rstHigh) begin
      if (rstHigh) grpOut[g] <= 1'b0;
      else         grpOut[g] <= ~ctl.cntNext[tap];
    end
    if (g > 0) begin : g_chk
      // R2: a slower group never rises while group A is low
      p_rise_with_a_r2: assert property (@(posedge clk) disable iff (rstHigh)
        (age != 2'd0 && $rose(grpOut[g])) |-> grpOut[0]);
    end
  end

  assign fbTap = ctl.fbSel ? TAP_W'(FB_FAST) : TAP_W'(FB_SLOW);

  always_ff @(posedge clk or posedge rstHigh) begin
    if (rstHigh) fbOut <= 1'b0;
    else         fbOut <= ~ctl.cntNext[fbTap];
  end

  always_ff @(posedge clk or posedge rstHigh) begin
    if (rstHigh)             age <= 2'd0;
    else if (age != 2'd3)    age <= age + 2'd1;
  end

  // R6: every group is high when the feedback clock rises
  p_aligned_rise_r6: assert property (@(posedge clk) disable iff (rstHigh)
    (age != 2'd0 && $rose(fbOut)) |-> (&grpOut));

  // R1: with the fast ratio held on group A, it flips every source cycle
  p_a_toggle_r1: assert property (@(posedge clk) disable iff (rstHigh)
    (age == 2'd3 && $past(!ctl.grpSel[0]) && $past(!ctl.grpSel[0], 2))
      |-> (grpOut[0] != $past(grpOut[0])));
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic           vcoClk,
  input  logic           testClk,
  input  logic           oscClk,
  input  logic           pllEnable,
  input  logic           refSelect,
  input  logic           masterReset,
  input  logic           selA,
  input  logic           selB,
  input  logic           selC,
  input  logic           selD,
  input  logic           fbSelect,
  output logic           outA,
  output logic           outB,
  output logic [C_N-1:0] outC,
  output logic [D_N-1:0] outD,
  output logic           fbOut
);
  logic               srcClk;
  ctrl_t              ctl;
  logic [NUM_GRP-1:0] grpOut;

  clkdiv_srcmux u_mux (
    .vcoClk(vcoClk), .testClk(testClk), .oscClk(oscClk),
    .pllEnable(pllEnable), .refSelect(refSelect), .srcClk(srcClk)
  );

  clkdiv_ctrl u_ctrl (
    .clk(srcClk), .rstHigh(masterReset),
    .rawSel({selD, selC, selB, selA}), .rawFb(fbSelect), .ctl(ctl)
  );

  clkdiv_datapath u_dp (
    .clk(srcClk), .rstHigh(masterReset), .ctl(ctl),
    .grpOut(grpOut), .fbOut(fbOut)
  );

  assign outA = grpOut[0];
  assign outB = grpOut[1];
  for (genvar i = 0; i < C_N; i++) begin : g_fanC
    assign outC[i] = grpOut[2];
  end
  for (genvar i = 0; i < D_N; i++) begin : g_fanD
    assign outD[i] = grpOut[3];
  end
endmodule

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int TEST_PERIOD = 26;
  localparam int OSC_PERIOD  = 34;
  localparam int WATCHDOG    = 150000 * CLK_PERIOD;

  typedef struct {
    int    sig;
    int    ratio;
    int    period;
    string req;
  } item_t;

  logic vcoClk = 1'b0, testClk = 1'b0, oscClk = 1'b0;
  logic pllEnable, refSelect, masterReset;
  logic selA, selB, selC, selD, fbSelect;
  logic outA, outB, fbOut;
  logic [1:0] outC;
  logic [4:0] outD;

  item_t sbQ[$];
  bit    busy = 1'b0;
  int    checks = 0, fails = 0, aRises = 0;

  always #(CLK_PERIOD/2)  vcoClk  = ~vcoClk;
  always #(TEST_PERIOD/2) testClk = ~testClk;
  always #(OSC_PERIOD/2)  oscClk  = ~oscClk;
  always @(posedge outA) aRises++;

  clkdiv_bank u_dut (
    .vcoClk(vcoClk), .testClk(testClk), .oscClk(oscClk),
    .pllEnable(pllEnable), .refSelect(refSelect), .masterReset(masterReset),
    .selA(selA), .selB(selB), .selC(selC), .selD(selD), .fbSelect(fbSelect),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD), .fbOut(fbOut)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitRise(int s);
    case (s)
      0: @(posedge outA);
      1: @(posedge outB);
      2: @(posedge outC[0]);
      3: @(posedge outD[0]);
      default: @(posedge fbOut);
    endcase
  endtask

  task automatic waitFall(int s);
    case (s)
      0: @(negedge outA);
      1: @(negedge outB);
      2: @(negedge outC[0]);
      3: @(negedge outD[0]);
      default: @(negedge fbOut);
    endcase
  endtask

  function automatic string sigReq(int s);
    if (s == 0) return "R1";
    if (s == 4) return "R3";
    return "R2";
  endfunction

  // monitor: pops expected items and measures the named output
  initial begin
    forever begin
      item_t it;
      time t0, t1, t2;
      wait (sbQ.size() > 0);
      busy = 1'b1;
      it = sbQ.pop_front();
      waitRise(it.sig);
      t0 = $time;
      #1;
      if (it.sig == 2) check(outC == 2'b11, "R10", "outC copies", int'(outC), 3);
      if (it.sig == 3) check(outD == 5'b11111, "R10", "outD copies", int'(outD), 31);
      waitFall(it.sig);
      t1 = $time;
      waitRise(it.sig);
      t2 = $time;
      check((t2 - t0) == it.ratio * it.period,
            (it.req == "") ? sigReq(it.sig) : it.req, "period",
            int'(t2 - t0), it.ratio * it.period);
      check((t1 - t0) == it.ratio * it.period / 2, "R4", "high time",
            int'(t1 - t0), it.ratio * it.period / 2);
      busy = 1'b0;
    end
  end

  task automatic pushItem(int s, int ratio, int p, string req);
    item_t it;
    it.sig = s; it.ratio = ratio; it.period = p; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    #1;
    wait (sbQ.size() == 0 && !busy);
  endtask

  // driver: applies a setting, lets it settle, queues expected ratios
  task automatic runConfig(logic [3:0] s, logic fb, logic pe, logic rs, int p, string req);
    {selD, selC, selB, selA} = s;
    fbSelect  = fb;
    pllEnable = pe;
    refSelect = rs;
    repeat (40) #p;
    pushItem(0, s[0] ? 4 : 2, p, req);
    pushItem(1, s[1] ? 8 : 4, p, req);
    pushItem(2, s[2] ? 8 : 4, p, req);
    pushItem(3, s[3] ? 8 : 4, p, req);
    pushItem(4, fb ? 8 : 16, p, req);
    drain();
  endtask

  task automatic allHigh(string req);
    check({outA, outB, outC, outD, fbOut} == 10'h3FF, req, "all outputs high",
          int'({outA, outB, outC, outD, fbOut}), 1023);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  initial begin
    int n0, n1;
    masterReset = 1'b1; pllEnable = 1'b1; refSelect = 1'b0;
    selA = 0; selB = 0; selC = 0; selD = 0; fbSelect = 0;
    #50;
    check({outA, outB, outC, outD, fbOut} == 10'h0, "R5", "outputs in reset",
          int'({outA, outB, outC, outD, fbOut}), 0);
    #53 masterReset = 1'b0;
    @(posedge outA); #1;
    allHigh("R6");

    // R1 R2 R3 R4 R10: every select combination with both feedback ratios
    for (int c = 0; c < 32; c++) runConfig(c[3:0], c[4], 1'b1, 1'b0, CLK_PERIOD, "");

    // R7: mid-frame change of selA is deferred to the wrap
    runConfig(4'b0000, 1'b0, 1'b1, 1'b0, CLK_PERIOD, "");
    @(posedge fbOut);
    #1;
    n0 = aRises;
    selA = 1'b1;
    #153;
    n1 = aRises;
    check((n1 - n0) == 7, "R7", "outA rises before wrap", n1 - n0, 7);
    @(posedge fbOut);
    pushItem(0, 4, CLK_PERIOD, "R7");
    drain();

    // R5 R6: reset asserted mid-run, then released
    #7 masterReset = 1'b1;
    #2;
    check({outA, outB, outC, outD, fbOut} == 10'h0, "R5", "async clear",
          int'({outA, outB, outC, outD, fbOut}), 0);
    #21 masterReset = 1'b0;
    @(posedge fbOut); #1;
    allHigh("R6");

    // R8 R9: bypass sources
    runConfig(4'b0000, 1'b1, 1'b0, 1'b1, TEST_PERIOD, "R8");
    runConfig(4'b1010, 1'b0, 1'b0, 1'b0, OSC_PERIOD, "R9");

    summary();
    $finish;
  end
endmodule